// File: doc/BRIEF.md
# Phase-to-Correction Lookup Interpolator

This block turns a signed relative phase measurement into a multiplicative correction coefficient for an oscillator's drive period. The phase word indexes a writable coefficient table; the two neighbouring entries are blended by linear interpolation on the low phase bits. The resulting coefficient K is then multiplied by the drive period, which yields a prediction of the resonance period that a later smoothing stage can use as the next drive target.

A host fills the table through a plain write port (address, data, enable) while the loop is being calibrated, and it can rewrite entries at any time afterwards. On the datapath side, a valid-qualified phase sample arrives roughly once every 25 clocks. The block answers each sample with one valid pulse a fixed four clocks later, carrying K and the predicted period.

Top module: `phase_corr_lut`

## Requirements
- R1: The table index is bits [24:17] of the phase with bit 24 inverted (the phase offset by +2^24, which maps -pi..+pi onto 0..255). The fraction is bits [16:0] of the phase.
- R2: K = e[i] + floor((e[i+1] - e[i]) * frac / 2^17), where e[] holds unsigned 2.22 entries and K uses the same 24-bit 2.22 format.
- R3: At index 255 the upper neighbour is entry 255 itself, so K equals e[255] for any fraction.
- R4: A zero fraction gives K exactly equal to e[i].
- R5: out_pred = floor(K * period / 2^22) as a 32-bit 12.20 value, where period is the 30-bit 10.20 drive period.
- R6: The drive period used for a lookup is the one present in the clock cycle where in_valid is high. Later changes do not affect that lookup.
- R7: out_valid is a one-cycle pulse exactly four clocks after each in_valid. out_k and out_pred change only with that pulse and hold their values otherwise.
- R8: A host write accepted at a clock edge is visible to every lookup whose in_valid is sampled at a later edge. Writes never change out_k, out_pred or out_valid by themselves.
- R9: While rst_n is low, out_valid, out_k and out_pred are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host table write strobe |
| wr_addr | input | 8 | Host table write address |
| wr_data | input | 24 | Host coefficient, unsigned 2.22 |
| in_valid | input | 1 | Phase sample strobe |
| in_phase | input | 25 | Signed 1.24 relative phase |
| drive_period | input | 30 | Current drive period, unsigned 10.20 |
| out_valid | output | 1 | Result strobe |
| out_k | output | 24 | Interpolated coefficient, unsigned 2.22 |
| out_pred | output | 32 | Predicted resonance period, unsigned 12.20 |

## Verification
Both out_k and out_pred are due on the fourth rising edge after the edge that samples in_valid. The bench drives each sample on a falling edge and checks on the third falling edge afterwards that no pulse has appeared yet. It compares both results on the fourth falling edge and confirms on the fifth that the pulse has dropped while the values hold. The drive period is changed one clock after each sample, and host writes are issued between lookups, so that R6 and R8 are checked in the same cycle frame.

// File: rtl/phcorr_pkg.sv
package phcorr_pkg;
  // Clocks from the in_valid sampling edge to the out_valid edge.
  localparam int unsigned PIPE_LAT = 4;

  // Upper neighbour index, held at the last entry.
  function automatic int unsigned upper_nbr(input int unsigned idx, input int unsigned depth);
    return (idx >= depth - 1) ? depth - 1 : idx + 1;
  endfunction
endpackage

// File: rtl/coef_table.sv
module coef_table #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 24,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr_lo,
  input  logic [AW-1:0]     rd_addr_hi,
  output logic [DATA_W-1:0] rd_lo,
  output logic [DATA_W-1:0] rd_hi
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Write port and two registered read ports; a read in the write cycle sees old data.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) begin
      rd_lo <= mem[rd_addr_lo];
      rd_hi <= mem[rd_addr_hi];
    end
  end

  // R3
  nbr_addr_chk: assert property (@(posedge clk)
    rd_en |-> (rd_addr_hi == rd_addr_lo) ? (rd_addr_lo == AW'(DEPTH - 1))
                                         : (rd_addr_hi == rd_addr_lo + AW'(1)));
endmodule

// File: rtl/interp_stage.sv
module interp_stage #(
  parameter int unsigned COEF_W = 24,
  parameter int unsigned FRAC_W = 17,
  parameter int unsigned PER_W  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic [COEF_W-1:0] e_lo,
  input  logic [COEF_W-1:0] e_hi,
  input  logic [FRAC_W-1:0] frac,
  input  logic [PER_W-1:0]  per,
  output logic              out_v,
  output logic [COEF_W-1:0] k,
  output logic [PER_W-1:0]  per_o
);
  localparam int unsigned DIFF_W = COEF_W + 1;
  localparam int unsigned PROD_W = DIFF_W + FRAC_W + 1;

  // Stage 2: slope
  logic                     v2_q, v2_d;
  logic signed [DIFF_W-1:0] diff_q, diff_d;
  logic [COEF_W-1:0]        e0_q;
  logic [FRAC_W-1:0]        frac_q;
  logic [PER_W-1:0]         per2_q;

  // Stage 3: multiply-add
  logic                     v3_q, v3_d;
  logic [COEF_W-1:0]        k_q, k_d;
  logic [PER_W-1:0]         per3_q;
  logic signed [PROD_W-1:0] prod, step;
  logic signed [COEF_W+1:0] sum;

  always_comb begin
    v2_d   = in_v;
    diff_d = $signed({1'b0, e_hi}) - $signed({1'b0, e_lo});
    v3_d   = v2_q;
    prod   = diff_q * $signed({1'b0, frac_q});
    step   = prod >>> FRAC_W;
    sum    = $signed({2'b00, e0_q}) + $signed(step[COEF_W+1:0]);
    k_d    = sum[COEF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v2_q <= v2_d;
      v3_q <= v3_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) begin
      diff_q <= diff_d;
      e0_q   <= e_lo;
      frac_q <= frac;
      per2_q <= per;
    end
    if (v2_q) begin
      k_q    <= k_d;
      per3_q <= per2_q;
    end
  end

  assign out_v = v3_q;
  assign k     = k_q;
  assign per_o = per3_q;

  // R2
  k_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v2_q |=> (int'(k_q) >= int'($past(e0_q)) + (($past(diff_q) < 0) ? int'($past(diff_q)) : 0)) &&
             (int'(k_q) <= int'($past(e0_q)) + (($past(diff_q) > 0) ? int'($past(diff_q)) : 0)));
  // R4
  zero_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && frac_q == '0) |=> (k_q == $past(e0_q)));
endmodule

// File: rtl/period_scaler.sv
module period_scaler #(
  parameter int unsigned COEF_W = 24,
  parameter int unsigned K_FRAC = 22,
  parameter int unsigned PER_W  = 30,
  localparam int unsigned PRED_W = COEF_W + PER_W - K_FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic [COEF_W-1:0] k,
  input  logic [PER_W-1:0]  per,
  output logic              out_v,
  output logic [COEF_W-1:0] k_o,
  output logic [PRED_W-1:0] pred
);
  logic [COEF_W+PER_W-1:0] prod;
  logic                    v_q, v_d;
  logic [COEF_W-1:0]       k_q, k_d;
  logic [PRED_W-1:0]       pred_q, pred_d;

  always_comb begin
    prod   = COEF_W'(k) * PER_W'(per);
    v_d    = in_v;
    k_d    = in_v ? k : k_q;
    pred_d = in_v ? prod[K_FRAC +: PRED_W] : pred_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      k_q    <= '0;
      pred_q <= '0;
    end else begin
      v_q    <= v_d;
      k_q    <= k_d;
      pred_q <= pred_d;
    end
  end

  assign out_v = v_q;
  assign k_o   = k_q;
  assign pred  = pred_q;

  // R5
  unity_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && k == COEF_W'(1 << K_FRAC)) |=> (pred_q == PRED_W'($past(per))));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_v |=> ($stable(k_q) && $stable(pred_q)));
endmodule

// File: rtl/phase_corr_lut.sv
module phase_corr_lut
  import phcorr_pkg::*;
#(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned PHASE_W = 25,
  parameter int unsigned COEF_W  = 24,
  parameter int unsigned K_FRAC  = 22,
  parameter int unsigned PER_W   = 30,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned FRAC_W = PHASE_W - IDX_W,
  localparam int unsigned PRED_W = COEF_W + PER_W - K_FRAC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [COEF_W-1:0]  wr_data,
  input  logic               in_valid,
  input  logic [PHASE_W-1:0] in_phase,
  input  logic [PER_W-1:0]   drive_period,
  output logic               out_valid,
  output logic [COEF_W-1:0]  out_k,
  output logic [PRED_W-1:0]  out_pred
);
  // Stage 0: offset the signed phase onto an unsigned index and fraction
  logic [PHASE_W-1:0] ph_off;
  logic [IDX_W-1:0]   idx_lo, idx_hi;
  logic [FRAC_W-1:0]  frac_d;

  always_comb begin
    ph_off = in_phase ^ PHASE_W'(1 << (PHASE_W - 1));
    idx_lo = ph_off[PHASE_W-1 -: IDX_W];
    frac_d = ph_off[FRAC_W-1:0];
    idx_hi = IDX_W'(upper_nbr(int'(idx_lo), DEPTH));
  end

  // Stage 1: table read, with fraction and period carried alongside
  logic              v1_q;
  logic [FRAC_W-1:0] frac1_q;
  logic [PER_W-1:0]  per1_q;
  logic [COEF_W-1:0] e_lo, e_hi;

  coef_table #(.DEPTH(DEPTH), .DATA_W(COEF_W)) table_i (
    .clk        (clk),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (in_valid),
    .rd_addr_lo (idx_lo),
    .rd_addr_hi (idx_hi),
    .rd_lo      (e_lo),
    .rd_hi      (e_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1_q <= 1'b0;
    else        v1_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      frac1_q <= frac_d;
      per1_q  <= drive_period;
    end
  end

  // Stages 2 and 3
  logic              v3;
  logic [COEF_W-1:0] k3;
  logic [PER_W-1:0]  per3;

  interp_stage #(.COEF_W(COEF_W), .FRAC_W(FRAC_W), .PER_W(PER_W)) interp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (v1_q),
    .e_lo  (e_lo),
    .e_hi  (e_hi),
    .frac  (frac1_q),
    .per   (per1_q),
    .out_v (v3),
    .k     (k3),
    .per_o (per3)
  );

  // Stage 4
  period_scaler #(.COEF_W(COEF_W), .K_FRAC(K_FRAC), .PER_W(PER_W)) scale_i (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (v3),
    .k     (k3),
    .per   (per3),
    .out_v (out_valid),
    .k_o   (out_k),
    .pred  (out_pred)
  );

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, PIPE_LAT));
  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_valid, PIPE_LAT - 1)) |=> !out_valid);
endmodule

// File: tb/phase_corr_lut_tb_top.sv
module phase_corr_lut_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [23:0] wr_data;
  logic        in_valid;
  logic [24:0] in_phase;
  logic [29:0] drive_period;
  logic        out_valid;
  logic [23:0] out_k;
  logic [31:0] out_pred;

  int n_tests = 0;
  int n_fail  = 0;
  longint tbl [256];
  int cyc = 0;

  always #10 clk = ~clk;

  phase_corr_lut dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_valid(in_valid), .in_phase(in_phase), .drive_period(drive_period),
    .out_valid(out_valid), .out_k(out_k), .out_pred(out_pred)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic host_write(input int a, input longint d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 24'(d);
    tbl[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic longint model_k(input int idx, input longint frac);
    longint e0, e1, d;
    e0 = tbl[idx];
    e1 = tbl[(idx == 255) ? 255 : idx + 1];
    d  = (e1 - e0) * frac;
    return e0 + (d >>> 17);
  endfunction

  // Drives one lookup and checks the pulse frame (R1, R2, R5, R6, R7)
  task automatic lookup(input string req, input int idx, input longint frac, input longint per);
    longint ek, ep;
    ek = model_k(idx, frac);
    ep = (ek * per) >> 22;
    @(negedge clk);
    in_valid = 1'b1;
    in_phase = 25'(((longint'(idx) << 17) | frac) ^ (64'd1 << 24));
    drive_period = 30'(per);
    @(negedge clk);
    in_valid = 1'b0;
    drive_period = ~30'(per); // R6: later change must not matter
    repeat (2) @(negedge clk);
    check("R7 early", longint'(out_valid), 0);
    @(negedge clk);
    check("R7 pulse", longint'(out_valid), 1);
    check({req, " k"}, longint'(out_k), ek);
    check("R5 R6 pred", longint'(out_pred), ep);
    @(negedge clk);
    check("R7 drop", longint'(out_valid), 0);
    check("R7 hold", longint'(out_k), ek);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    in_valid = 1'b0; in_phase = '0; drive_period = '0;
    repeat (3) @(negedge clk);
    // R9
    check("R9 valid", longint'(out_valid), 0);
    check("R9 k", longint'(out_k), 0);
    check("R9 pred", longint'(out_pred), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 256; i++) host_write(i, (64'd1 << 22) + ((longint'(i) * 7919) % (64'd1 << 21)) - (64'd1 << 20));

    // R1 R2 sweep every index with several fractions
    for (int i = 0; i < 256; i++) begin
      lookup("R4", i, 0, 64'd5 << 20);
      lookup("R1 R2", i, 64'd1 << 16, (longint'(i) + 3) << 18);
      lookup("R1 R2", i, 64'h1FFFF, 64'h3FFFFFFF);
      lookup("R2", i, (longint'(i) * 4099) % (64'd1 << 17), 64'd1 << 20);
    end
    // R3 top index clamps the neighbour
    lookup("R3", 255, 64'h1FFFF, 64'd7 << 20);
    check("R3 top equals last entry", longint'(out_k), tbl[255]);

    // R5 unity coefficient passes the period through
    host_write(40, 64'd1 << 22);
    lookup("R5", 40, 0, 64'h2ABCDEF1);
    check("R5 unity", longint'(out_pred), 64'h2ABCDEF1);

    // R8 writes change later lookups only, not outputs
    begin
      longint hk;
      hk = longint'(out_k);
      host_write(10, 64'hFFFFFF);
      host_write(11, 64'h000001);
      check("R8 no output change k", longint'(out_k), hk);
      check("R8 no output valid", longint'(out_valid), 0);
    end
    lookup("R8 new entries", 10, 64'h0C000, 64'd9 << 20);
    lookup("R8 R2 falling slope", 10, 64'h1FFFF, 64'd1 << 20);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule